// File: doc/BRIEF.md
# Peripheral Page Bit Set/Clear/Test Unit

This unit carries out single-bit operations on the 64 nibble-wide control locations at the top of a 16-bit data address space, FFC0H to FFFFH. A request carries a 6-bit page offset, a 2-bit bit index and a 2-bit operation code. The unit adds the offset to the fixed page base to form the full address. It then reads the addressed nibble over a simple synchronous memory port.

For a set or clear request, the unit writes the nibble back in the following cycle with only the chosen bit forced. For a test request, no write is issued. Instead, a zero flag reports whether the chosen bit was 0.

A `busy_o`/`done_o` pair tells the issuing pipeline when the operation has finished. The memory port expects read data one clock after the read strobe.

Top module: `iobit_rmw_unit`

## Requirements
- R1: Every memory access of an operation uses address FFC0H + `field_i` (zero-extended), so offsets 00H..3FH reach FFC0H..FFFFH.
- R2: Op code 2'b01 (set) writes back the read nibble with bit `bidx_i` forced to 1 and the other three bits unchanged.
- R3: Op code 2'b00 (clear) writes back the read nibble with bit `bidx_i` forced to 0 and the other three bits unchanged.
- R4: Op codes 2'b10 and 2'b11 (test) issue no write. When done, `zero_o` is 1 if the selected bit was 0 and 0 if it was 1.
- R5: `zero_o` changes only when a test completes. Set and clear leave it unchanged.
- R6: Each operation issues exactly one read, in the first cycle after acceptance. For set or clear it issues exactly one write, in the second cycle. Read and write are never asserted together.
- R7: A request with `req_i` high at a clock edge while `busy_o` is low is accepted. `busy_o` is then high for exactly two cycles, and `done_o` pulses for one cycle right after. Requests arriving while busy are ignored.
- R8: After reset, `busy_o`, `done_o`, `zero_o`, `mem_rd_o` and `mem_wr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request |
| op_i | input | 2 | 00 clear, 01 set, 10/11 test |
| field_i | input | 6 | Offset into the peripheral page |
| bidx_i | input | 2 | Bit index within the nibble |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| zero_o | output | 1 | Zero flag from the last test |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 4 | Write data |
| mem_rdata_i | input | 4 | Read data, valid the cycle after `mem_rd_o` |

## Verification
If a request is accepted at edge N, the read strobe and address appear in the cycle after edge N. The write strobe and its data follow in the cycle after edge N+1. `done_o`, the updated zero flag and the updated memory word are due after edge N+2.

The bench drives inputs on falling edges. It samples each of these three cycles at the following falling edge, so it compares against the exact cycle in which each result is due. It also counts read and write strobes across each operation to confirm the access counts.

// File: rtl/iobit_pkg.sv
package iobit_pkg;
  typedef enum logic [1:0] {
    OP_CLR  = 2'b00,
    OP_SET  = 2'b01,
    OP_TST  = 2'b10,
    OP_TSTA = 2'b11
  } bit_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RD   = 2'b01,
    ST_EXE  = 2'b10
  } seq_st_e;

  function automatic logic op_writes(bit_op_e op);
    return (op == OP_CLR) || (op == OP_SET);
  endfunction
endpackage

// File: rtl/iobit_addr_map.sv
module iobit_addr_map #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned FIELD_W   = 6,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hFFC0
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned PAD_W = ADDR_W - FIELD_W;

  assign addr_o = PAGE_BASE + {{PAD_W{1'b0}}, field_i};
endmodule

// File: rtl/iobit_bit_alu.sv
module iobit_bit_alu
  import iobit_pkg::*;
#(
  parameter int unsigned DATA_W = 4,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  bit_op_e           op_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              sel_bit_o
);
  logic force_val;
  assign force_val = (op_i == OP_SET);

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign mask_o[g]  = (idx_i == IDX_W'(g));
    assign wdata_o[g] = mask_o[g] ? force_val : rdata_i[g];
  end

  assign sel_bit_o = |(rdata_i & mask_o);
endmodule

// File: rtl/iobit_seq.sv
module iobit_seq
  import iobit_pkg::*;
#(
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  bit_op_e            op_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               sel_bit_i,
  output bit_op_e            op_o,
  output logic [FIELD_W-1:0] field_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               zero_o
);
  seq_st_e state_q, state_d;
  logic    accept;

  assign accept = req_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_RD;
      ST_RD:   state_d = ST_EXE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_o    <= OP_CLR;
      field_o <= '0;
      idx_o   <= '0;
      done_o  <= 1'b0;
      zero_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_q == ST_EXE);
      if (accept) begin
        op_o    <= op_i;
        field_o <= field_i;
        idx_o   <= idx_i;
      end
      if ((state_q == ST_EXE) && !op_writes(op_o)) zero_o <= ~sel_bit_i;
    end
  end

  assign rd_o   = (state_q == ST_RD);
  assign wr_o   = (state_q == ST_EXE) && op_writes(op_o);
  assign busy_o = (state_q != ST_IDLE);

  // R6: write only right after the single read
  p_wr_after_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(rd_o));
  p_rd_wr_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  p_rd_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o);
  // R7: two busy cycles then a done pulse
  p_busy_two_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/iobit_rmw_unit.sv
module iobit_rmw_unit
  import iobit_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned DATA_W  = 4,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hFFC0,
  localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [1:0]         op_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [IDX_W-1:0]   bidx_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               zero_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  bit_op_e            op_q;
  logic [FIELD_W-1:0] field_q;
  logic [IDX_W-1:0]   idx_q;
  logic               sel_bit;
  logic [DATA_W-1:0]  mask;

  iobit_seq #(.FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .op_i      (bit_op_e'(op_i)),
    .field_i   (field_i),
    .idx_i     (bidx_i),
    .sel_bit_i (sel_bit),
    .op_o      (op_q),
    .field_o   (field_q),
    .idx_o     (idx_q),
    .rd_o      (mem_rd_o),
    .wr_o      (mem_wr_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .zero_o    (zero_o)
  );

  iobit_addr_map #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .PAGE_BASE(PAGE_BASE)) u_map (
    .field_i (field_q),
    .addr_o  (mem_addr_o)
  );

  iobit_bit_alu #(.DATA_W(DATA_W)) u_alu (
    .rdata_i   (mem_rdata_i),
    .idx_i     (idx_q),
    .op_i      (op_q),
    .mask_o    (mask),
    .wdata_o   (mem_wdata_o),
    .sel_bit_o (sel_bit)
  );

  // R1: accesses stay inside the peripheral page
  p_in_page_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> (mem_addr_o >= PAGE_BASE));
  // R1: write address equals read address
  p_same_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $stable(mem_addr_o));
  // R2/R3: write-back differs from read data in at most one bit
  p_one_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($countones(mem_wdata_o ^ mem_rdata_i) <= 1));
  p_keep_others_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (((mem_wdata_o ^ mem_rdata_i) & ~mask) == '0));
  // R5: zero flag moves only on completion
  p_zero_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(zero_o));
endmodule

// File: tb/iobit_rmw_unit_bench.sv
`timescale 1ns/1ps
module iobit_rmw_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [5:0]  field = '0;
  logic [1:0]  bidx = '0;
  logic        busy, done, zero, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [3:0]  mem_wdata;
  logic [3:0]  mem_rdata = '0;
  logic [3:0]  mem [64];

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cnt  = 0;
  int wr_cnt  = 0;
  int cycles  = 0;
  logic zero_exp = 1'b0;

  always #4 clk = ~clk;

  iobit_rmw_unit u_iobit_rmw_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .field_i(field),
    .bidx_i(bidx), .busy_o(busy), .done_o(done), .zero_o(zero),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // behavioural nibble memory for the peripheral page
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
    if (mem_rd) rd_cnt <= rd_cnt + 1;
    if (mem_wr) wr_cnt <= wr_cnt + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_word(logic [1:0] o, logic [1:0] b, logic [3:0] w);
    logic [3:0] r = w;
    if (o == 2'b01) r[b] = 1'b1;
    else if (o == 2'b00) r[b] = 1'b0;
    return r;
  endfunction

  task automatic run_op(logic [1:0] o, logic [5:0] f, logic [1:0] b, bit hold);
    logic [3:0] old_w = mem[f];
    logic [3:0] new_w = exp_word(o, b, old_w);
    bit         wr_op = (o == 2'b00) || (o == 2'b01);
    int         rd0, wr0;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req = 1'b1; op = o; field = f; bidx = b;
    @(negedge clk);
    if (!hold) req = 1'b0;
    // change op fields while busy: must not matter (R7)
    op = ~o; field = ~f; bidx = ~b;
    check("R6 rd strobe", {31'd0, mem_rd}, 1);
    check("R1 rd addr", {16'd0, mem_addr}, 32'hFFC0 + f);
    check("R7 busy1", {31'd0, busy}, 1);
    @(negedge clk);
    check("R7 busy2", {31'd0, busy}, 1);
    check("R6 wr strobe", {31'd0, mem_wr}, {31'd0, wr_op});
    if (wr_op) begin
      check("R1 wr addr", {16'd0, mem_addr}, 32'hFFC0 + f);
      check(o == 2'b01 ? "R2 set data" : "R3 clr data", {28'd0, mem_wdata}, {28'd0, new_w});
    end
    @(negedge clk);
    req = 1'b0;
    check("R7 done", {31'd0, done}, 1);
    check("R7 not busy", {31'd0, busy}, 0);
    if (!wr_op) zero_exp = ~old_w[b];
    check(wr_op ? "R5 zero kept" : "R4 zero flag", {31'd0, zero}, {31'd0, zero_exp});
    check(wr_op ? "R2 R3 mem word" : "R4 no write", {28'd0, mem[f]}, {28'd0, new_w});
    check("R6 read count", rd_cnt - rd0, 1);
    check("R6 write count", wr_cnt - wr0, wr_op ? 1 : 0);
    @(negedge clk);
    check("R7 done pulse", {31'd0, done}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem[i] = 4'($urandom);
    #1;
    check("R8 busy", {31'd0, busy}, 0);
    check("R8 done", {31'd0, done}, 0);
    check("R8 zero", {31'd0, zero}, 0);
    check("R8 strobes", {30'd0, mem_rd, mem_wr}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    mem[0] = 4'h0; mem[63] = 4'hF;
    run_op(2'b10, 6'h00, 2'd3, 0);   // R4 bit 0 -> zero=1
    run_op(2'b01, 6'h00, 2'd3, 0);   // R2
    run_op(2'b11, 6'h00, 2'd3, 0);   // R4 alternate test code, bit 1 -> zero=0
    run_op(2'b00, 6'h3F, 2'd0, 0);   // R3 at top address
    run_op(2'b00, 6'h3F, 2'd0, 0);   // R3 already clear
    run_op(2'b10, 6'h3F, 2'd0, 1);   // R7 req held while busy
    run_op(2'b01, 6'h15, 2'd2, 1);
    for (int i = 0; i < 300; i++)
      run_op(2'($urandom), 6'($urandom), 2'($urandom), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule